// File: doc/BRIEF.md
# Spreading Code and Navigation Bit Generator

This block makes the 1023-chip spreading sequence of one satellite from a pair of 10-bit shift registers. It also makes a synthetic navigation bit stream that is tied to the code period, and the transmit chip, which is the code chip XOR the navigation bit. The same block serves as the local replica inside a receiver channel and as a source of test signals.

Timing comes from a clock enable at twice the chip rate. Each chip lasts two accepted enable pulses. The chip stream has no flow control. Every output is a level that holds until the next accepted enable, so there is no back-pressure and no valid/ready pair; the enable paces the stream. A slip request lets a receiver search or track in half-chip steps. The satellite is picked by two phase-select taps on the second register.

Top module: `ca_nav_gen`

## Requirements
- R1: While rst_n is low, and after it rises, both code registers hold all ones, the chip counter and the millisecond counter are zero, and the navigation register holds all ones. The first outputs are chip_o=1, epoch_o=1, data_o=1 and tx_chip_o=0.
- R2: The code advances one chip for every two accepted tick2x_i pulses. A pulse is accepted when tick2x_i is high and slip_i is low. The first register uses feedback from stages 3 and 10. The second uses stages 2, 3, 6, 8, 9 and 10. Stage 1 takes the feedback.
- R3: chip_o is first-register stage 10 XOR second-register stage tap_a_i XOR second-register stage tap_b_i. Read MSB first, the first ten chips after reset are: taps 2/6 give 1100100000, taps 3/7 give 1110010000, taps 4/8 give 1111001000, and taps 5/9 give 1111100100.
- R4: A tap value outside 1..10 adds nothing. Two equal taps cancel. In both cases chip_o follows the first register alone, whose first ten chips are 1111111111.
- R5: epoch_o is high exactly while chip 0 of each 1023-chip period is current. It therefore recurs every 2046 accepted pulses, and the code repeats from its first chip.
- R6: data_o changes only at the start of a code period, once every 20 periods. It comes from a 7-bit register with feedback from stages 6 and 7, seeded with all ones. The output is the newest bit, so the first bit is 1 and the second is 0.
- R7: tx_chip_o equals chip_o XOR data_o at all times.
- R8: A tick2x_i pulse that arrives with slip_i high is dropped. No register changes, and the code phase falls back by exactly half a chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick2x_i | input | 1 | Enable at twice the chip rate |
| slip_i | input | 1 | Drop the current tick2x_i pulse (half-chip delay) |
| tap_a_i | input | 4 | First phase-select stage of the second register (1..10) |
| tap_b_i | input | 4 | Second phase-select stage of the second register (1..10) |
| chip_o | output | 1 | Current code chip |
| epoch_o | output | 1 | High during chip 0 of each code period |
| data_o | output | 1 | Current navigation bit |
| tx_chip_o | output | 1 | Code chip XOR navigation bit |

## Verification
All state updates on the clock edge where a tick2x_i pulse is accepted, and every output is decoded from that state without further registers. A new chip, epoch or bit therefore shows up right after the edge of the second accepted pulse. The bench changes inputs and samples outputs on the falling edge. After each run of pulses, it reads the outputs at the falling edge that follows the last accepted pulse. It checks the period boundary one pulse before and one pulse after the 2046th and the 40920th pulse. It also checks that a slipped pulse pushes the first epoch change back by exactly one pulse.

// File: rtl/ca_gen_pkg.sv
package ca_gen_pkg;
  localparam int unsigned CODE_REG_W = 10;
  localparam logic [CODE_REG_W-1:0] G1_FB_MASK = 10'h204;  // stages 3,10
  localparam logic [CODE_REG_W-1:0] G2_FB_MASK = 10'h3A6;  // stages 2,3,6,8,9,10
  localparam int unsigned NAV_REG_W = 7;
  localparam logic [NAV_REG_W-1:0] NAV_FB_MASK = 7'h60;    // stages 6,7
endpackage

// File: rtl/ca_phase_gate.sv
module ca_phase_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick2x_i,
  input  logic slip_i,
  output logic step_o
);
  logic half_q;
  logic accept;

  assign accept = tick2x_i && !slip_i;
  assign step_o = accept && half_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      half_q <= 1'b0;
    else if (accept) half_q <= ~half_q;
  end

  // R8
  slip_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick2x_i && slip_i) |=> $stable(half_q));
endmodule

// File: rtl/ca_shift_gen.sv
module ca_shift_gen #(
  parameter int unsigned W = 10,
  parameter logic [W-1:0] FB_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] stages_o
);
  logic [W-1:0] sr_q;
  logic         fb;

  assign fb       = ^(sr_q & FB_MASK);
  assign stages_o = sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      sr_q <= '1;
    else if (step_i) sr_q <= {sr_q[W-2:0], fb};
  end

  // R2
  no_lockup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q != '0);
endmodule

// File: rtl/ca_epoch_ctr.sv
module ca_epoch_ctr #(
  parameter int unsigned CHIP_LEN   = 1023,
  parameter int unsigned MS_PER_BIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  output logic epoch_o,
  output logic bit_step_o
);
  localparam int unsigned CW = $clog2(CHIP_LEN);
  localparam int unsigned MW = $clog2(MS_PER_BIT);
  localparam logic [CW-1:0] CHIP_LAST = CW'(CHIP_LEN - 1);
  localparam logic [MW-1:0] MS_LAST   = MW'(MS_PER_BIT - 1);

  logic [CW-1:0] chip_q;
  logic [MW-1:0] ms_q;
  logic          wrap;

  assign wrap       = step_i && (chip_q == CHIP_LAST);
  assign epoch_o    = (chip_q == '0);
  assign bit_step_o = wrap && (ms_q == MS_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chip_q <= '0;
      ms_q   <= '0;
    end else if (step_i) begin
      chip_q <= wrap ? '0 : chip_q + 1'b1;
      if (wrap) ms_q <= (ms_q == MS_LAST) ? '0 : ms_q + 1'b1;
    end
  end

  // R5
  chip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_q <= CHIP_LAST);
  // R6
  ms_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ms_q <= MS_LAST);
endmodule

// File: rtl/ca_nav_gen.sv
module ca_nav_gen
  import ca_gen_pkg::*;
#(
  parameter int unsigned CHIP_LEN   = 1023,
  parameter int unsigned MS_PER_BIT = 20,
  parameter int unsigned TAP_W      = $clog2(CODE_REG_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick2x_i,
  input  logic             slip_i,
  input  logic [TAP_W-1:0] tap_a_i,
  input  logic [TAP_W-1:0] tap_b_i,
  output logic             chip_o,
  output logic             epoch_o,
  output logic             data_o,
  output logic             tx_chip_o
);
  logic                  step;
  logic                  bit_step;
  logic [CODE_REG_W-1:0] g1_q;
  logic [CODE_REG_W-1:0] g2_q;
  logic [NAV_REG_W-1:0]  nav_q;
  logic                  g2_sel;

  ca_phase_gate u_gate (
    .clk(clk), .rst_n(rst_n), .tick2x_i(tick2x_i), .slip_i(slip_i), .step_o(step)
  );

  ca_shift_gen #(.W(CODE_REG_W), .FB_MASK(G1_FB_MASK)) u_g1 (
    .clk(clk), .rst_n(rst_n), .step_i(step), .stages_o(g1_q)
  );

  ca_shift_gen #(.W(CODE_REG_W), .FB_MASK(G2_FB_MASK)) u_g2 (
    .clk(clk), .rst_n(rst_n), .step_i(step), .stages_o(g2_q)
  );

  ca_epoch_ctr #(.CHIP_LEN(CHIP_LEN), .MS_PER_BIT(MS_PER_BIT)) u_ctr (
    .clk(clk), .rst_n(rst_n), .step_i(step), .epoch_o(epoch_o), .bit_step_o(bit_step)
  );

  ca_shift_gen #(.W(NAV_REG_W), .FB_MASK(NAV_FB_MASK)) u_nav (
    .clk(clk), .rst_n(rst_n), .step_i(bit_step), .stages_o(nav_q)
  );

  // Out-of-range taps add nothing; equal taps cancel.
  always_comb begin
    g2_sel = 1'b0;
    for (int k = 1; k <= CODE_REG_W; k++) begin
      if (tap_a_i == TAP_W'(k)) g2_sel = g2_sel ^ g2_q[k-1];
      if (tap_b_i == TAP_W'(k)) g2_sel = g2_sel ^ g2_q[k-1];
    end
  end

  assign chip_o    = g1_q[CODE_REG_W-1] ^ g2_sel;
  assign data_o    = nav_q[0];
  assign tx_chip_o = chip_o ^ data_o;

  // R5
  epoch_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    epoch_o |-> (g1_q == '1 && g2_q == '1));
  // R6
  data_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_o != $past(data_o)) |-> epoch_o);
  // R8
  slip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick2x_i && slip_i) |=> ($stable(g1_q) && $stable(g2_q)));
endmodule

// File: tb/tb_ca_nav_gen.sv
module tb_ca_nav_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick2x_i = 1'b0;
  logic       slip_i = 1'b0;
  logic [3:0] tap_a_i = 4'd2;
  logic [3:0] tap_b_i = 4'd6;
  logic       chip_o, epoch_o, data_o, tx_chip_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ca_nav_gen dut (
    .clk(clk), .rst_n(rst_n), .tick2x_i(tick2x_i), .slip_i(slip_i),
    .tap_a_i(tap_a_i), .tap_b_i(tap_b_i),
    .chip_o(chip_o), .epoch_o(epoch_o), .data_o(data_o), .tx_chip_o(tx_chip_o)
  );

  // {tap_a, tap_b, first ten chips MSB first}
  localparam logic [17:0] VEC [6] = '{
    {4'd2, 4'd6,  10'b1100100000},  // R3
    {4'd3, 4'd7,  10'b1110010000},  // R3
    {4'd4, 4'd8,  10'b1111001000},  // R3
    {4'd5, 4'd9,  10'b1111100100},  // R3
    {4'd5, 4'd5,  10'b1111111111},  // R4 equal taps
    {4'd0, 4'd15, 10'b1111111111}   // R4 out of range
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick2x_i = 1'b0; slip_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ticks(input int n, input logic slp);
    for (int i = 0; i < n; i++) begin
      tick2x_i = 1'b1; slip_i = slp;
      @(negedge clk);
    end
    tick2x_i = 1'b0; slip_i = 1'b0;
  endtask

  initial begin
    #(4 * 190000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R3 R4: table of first chips
    for (int v = 0; v < 6; v++) begin
      logic [9:0] got;
      tap_a_i = VEC[v][17:14];
      tap_b_i = VEC[v][13:10];
      do_reset();
      for (int c = 0; c < 10; c++) begin
        got[9-c] = chip_o;
        ticks(2, 1'b0);
      end
      check($sformatf("R3/R4 row %0d", v), 32'(got), 32'(VEC[v][9:0]));
    end

    // R1 reset state
    tap_a_i = 4'd2; tap_b_i = 4'd6;
    do_reset();
    check("R1 chip", 32'(chip_o), 32'd1);
    check("R1 epoch", 32'(epoch_o), 32'd1);
    check("R1 data", 32'(data_o), 32'd1);
    check("R1 tx", 32'(tx_chip_o), 32'd0);

    // R2 R5: epoch after 2046 pulses
    ticks(2, 1'b0);
    check("R2 epoch low after one chip", 32'(epoch_o), 32'd0);
    ticks(2043, 1'b0);
    check("R5 epoch low at last chip", 32'(epoch_o), 32'd0);
    ticks(1, 1'b0);
    check("R5 epoch at 2046", 32'(epoch_o), 32'd1);
    check("R5 code restarts", 32'(chip_o), 32'd1);
    ticks(2, 1'b0);
    check("R5 second chip repeats", 32'(chip_o), 32'd1);
    ticks(4, 1'b0);
    check("R5 fourth chip repeats", 32'(chip_o), 32'd0);

    // R6 R7: bit boundary at 40920 pulses (2052 spent so far)
    ticks(40920 - 2052 - 1, 1'b0);
    check("R6 data before boundary", 32'(data_o), 32'd1);
    check("R6 epoch before boundary", 32'(epoch_o), 32'd0);
    check("R7 tx before boundary", 32'(tx_chip_o), 32'(chip_o ^ 1'b1));
    ticks(1, 1'b0);
    check("R6 data after boundary", 32'(data_o), 32'd0);
    check("R6 epoch at boundary", 32'(epoch_o), 32'd1);
    check("R7 tx after boundary", 32'(tx_chip_o), 32'd1);

    // R8 slip
    do_reset();
    ticks(1, 1'b1);
    ticks(1, 1'b0);
    check("R8 slipped pulse dropped", 32'(epoch_o), 32'd1);
    ticks(1, 1'b0);
    check("R8 chip after slip", 32'(epoch_o), 32'd0);
    check("R8 chip value after slip", 32'(chip_o), 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule